// File: doc/BRIEF.md
# Three-State Phase Detector with Guarded Pump Settings

This block compares the rising edges of two divided clocks: the output of a reference divider and the output of a main (loop) divider. It produces an up pulse and a down pulse for an external charge pump, which sources current for up and sinks current for down. The pulse widths follow the phase relation of the two edges. When both pulses are high, the detector clears them on the next clock. A coincident pair of edges therefore gives a single one-cycle pulse on both outputs.

The block also holds the pump settings that a control bus writes. These are a 2-bit current-magnitude code, a bit that switches the pump off, and an enable bit for the loop-filter amplifier. A write counts only when the bus raises its write-complete strobe. The pump code and the off bit then wait in a shadow register. They move to the outputs only on a clock where the pump is idle and no new edge is arriving, so a pulse never sees its current change part-way through. The amplifier enable is not guarded: it is registered on the strobe.

Top module: `pfd_guarded_pump`

## Requirements
- R1: When the reference input rises while both pump outputs are low and the pump is on, pump_up_o is high from the next clock. It stays high until the main-divider input rises.
- R2: When the main-divider input rises while both pump outputs are low and the pump is on, pump_dn_o is high from the next clock. It stays high until the reference input rises.
- R3: When pump_up_o and pump_dn_o are both high, both are low on the next clock, so the overlap lasts exactly one cycle. Rising edges on both inputs in the same cycle give one cycle with both outputs high.
- R4: The code on cfg_cur_i (bit 1 is the MSB) and the bit on cfg_off_i are captured only in a cycle where cfg_wr_done_i is high; without the strobe they are ignored. With the pump idle, a captured setting appears on pump_cur_o and pump_off_o two clocks after the strobe cycle.
- R5: A captured setting is applied only on a clock where both pump outputs are low and neither input is rising (rises are not counted while the pump is off). pump_cur_o and pump_off_o never change in a cycle where pump_up_o or pump_dn_o is high.
- R6: If a second write completes before a waiting setting is applied, the second setting replaces the first. The first never appears at the outputs.
- R7: While pump_off_o is 1, pump_up_o and pump_dn_o stay 0 and input edges are ignored. Once pump_off_o returns to 0, detection resumes.
- R8: amp_en_o takes the value of cfg_amp_en_i on the clock after a write-complete strobe, whether or not a pump pulse is active.
- R9: After a synchronous active-low reset, pump_up_o and pump_dn_o are 0, pump_cur_o is 00, pump_off_o is 0, amp_en_o is 1 and no setting is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_div_i | input | 1 | Reference-divider output (level, rising edge used) |
| main_div_i | input | 1 | Main-divider output (level, rising edge used) |
| cfg_wr_done_i | input | 1 | Bus write-complete strobe, one cycle |
| cfg_cur_i | input | 2 | Written pump current code |
| cfg_off_i | input | 1 | Written pump off bit (1 = pump off) |
| cfg_amp_en_i | input | 1 | Written loop-filter amplifier enable |
| pump_up_o | output | 1 | Source pulse to the charge pump |
| pump_dn_o | output | 1 | Sink pulse to the charge pump |
| pump_cur_o | output | 2 | Applied pump current code |
| pump_off_o | output | 1 | Applied pump off bit |
| amp_en_o | output | 1 | Registered amplifier enable |

## Verification
Two things can fall in the same cycle: a waiting setting becoming due, and a pump pulse starting because an input edge arrives. The bench provokes this by completing a write while the pump is idle and raising the reference input on the very next clock. It then expects the old code to stay in place for the whole pulse and the overlap cycle, and the new code to appear on the first quiet clock after the pulse. A second case places a write strobe inside an active up pulse. Every cycle of both sequences is compared, so a code change in any pulse cycle is reported.

// File: rtl/pfd_pkg.sv
// Package: shared widths, the pump settings record and the detector state
// encoding for the guarded three-state phase detector.
package pfd_pkg;

    // Width of the charge-pump current magnitude code.
    localparam int PUMP_CODE_W = 2;
    // Number of compared inputs (reference divider, main divider).
    localparam int NUM_CMP_IN  = 2;
    // Index of each compared input inside the edge vector.
    localparam int IDX_REF     = 0;
    localparam int IDX_MAIN    = 1;

    // Settings that are applied only while the pump is idle.
    typedef struct packed {
        logic [PUMP_CODE_W-1:0] code;
        logic                   off;
    } pump_cfg_t;

    localparam pump_cfg_t CFG_RESET = '{code: '0, off: 1'b0};

    // Detector state: idle, sourcing, sinking, or clearing an overlap.
    typedef enum logic [1:0] {
        PFD_IDLE = 2'b00,
        PFD_UP   = 2'b01,
        PFD_DN   = 2'b10,
        PFD_CLR  = 2'b11
    } pfd_state_e;

endpackage

// File: rtl/pfd_edge_detect.sv
// Module: pfd_edge_detect
// Finds rising edges on NUM_CH level inputs. Each input is compared with its
// value at the previous clock. Assumes the inputs are already synchronous to
// clk and are held low while rst_n is low.
module pfd_edge_detect #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] lvl_i,
    output logic [NUM_CH-1:0] rise_o
);

    logic [NUM_CH-1:0] lvl_prev;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Remember the previous level of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_prev[ch] <= 1'b0;
            end else begin
                lvl_prev[ch] <= lvl_i[ch];
            end
        end

        // A rise is a high level now that was low at the previous clock.
        assign rise_o[ch] = lvl_i[ch] & ~lvl_prev[ch];
    end

endmodule

// File: rtl/pfd_core.sv
// Module: pfd_core
// Three-state phase/frequency detector. A reference rise raises up, a main
// rise raises down, and when both are up the state clears on the next clock,
// giving a one-cycle overlap. While off_i is high the state is held idle and
// edges are ignored. Outputs come straight from the state register.
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise_i,
    input  logic main_rise_i,
    input  logic off_i,
    output logic up_o,
    output logic dn_o
);

    pfd_state_e state_q;
    pfd_state_e state_d;

    // Next-state selection from the current state and the two edges.
    always_comb begin
        state_d = state_q;
        if (off_i) begin
            state_d = PFD_IDLE;
        end else begin
            unique case (state_q)
                PFD_IDLE: begin
                    if (ref_rise_i && main_rise_i) begin
                        state_d = PFD_CLR;
                    end else if (ref_rise_i) begin
                        state_d = PFD_UP;
                    end else if (main_rise_i) begin
                        state_d = PFD_DN;
                    end
                end
                PFD_UP: begin
                    if (main_rise_i) begin
                        state_d = PFD_CLR;
                    end
                end
                PFD_DN: begin
                    if (ref_rise_i) begin
                        state_d = PFD_CLR;
                    end
                end
                PFD_CLR: begin
                    state_d = PFD_IDLE;
                end
                default: begin
                    state_d = PFD_IDLE;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PFD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Decode the pump pulses from the registered state.
    always_comb begin
        up_o = (state_q == PFD_UP) || (state_q == PFD_CLR);
        dn_o = (state_q == PFD_DN) || (state_q == PFD_CLR);
    end

endmodule

// File: rtl/pfd_cfg_guard.sv
// Module: pfd_cfg_guard
// Holds the pump settings. A write-complete strobe loads the shadow register,
// and a newer strobe overwrites it. The shadow moves to the applied settings
// only when busy_i is low. The amplifier enable is registered on the strobe
// without the guard. Assumes busy_i already covers pulses and edges that are
// arriving.
module pfd_cfg_guard
    import pfd_pkg::*;
#(
    parameter bit AMP_RST = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_done_i,
    input  pump_cfg_t wr_cfg_i,
    input  logic      wr_amp_i,
    input  logic      busy_i,
    output pump_cfg_t cfg_o,
    output logic      amp_o
);

    pump_cfg_t shadow_q;
    logic      pend_q;
    logic      apply;

    // A waiting setting may move only while the pump is quiet.
    assign apply = pend_q & ~busy_i;

    // Shadow register: the newest completed write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= CFG_RESET;
            pend_q   <= 1'b0;
        end else if (wr_done_i) begin
            shadow_q <= wr_cfg_i;
            pend_q   <= 1'b1;
        end else if (apply) begin
            pend_q   <= 1'b0;
        end
    end

    // Applied settings: loaded from the shadow at a quiet clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= CFG_RESET;
        end else if (apply) begin
            cfg_o <= shadow_q;
        end
    end

    // Amplifier enable: registered on the strobe, not guarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amp_o <= AMP_RST;
        end else if (wr_done_i) begin
            amp_o <= wr_amp_i;
        end
    end

endmodule

// File: rtl/pfd_guarded_pump.sv
// Module: pfd_guarded_pump (top)
// Phase detector with pump settings that are never switched in the middle of
// a pulse. Assumes both divider outputs are synchronous to clk and that the
// bus raises cfg_wr_done_i for one cycle per completed write.
module pfd_guarded_pump
    import pfd_pkg::*;
#(
    parameter bit AMP_RST = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ref_div_i,
    input  logic                   main_div_i,
    input  logic                   cfg_wr_done_i,
    input  logic [PUMP_CODE_W-1:0] cfg_cur_i,
    input  logic                   cfg_off_i,
    input  logic                   cfg_amp_en_i,
    output logic                   pump_up_o,
    output logic                   pump_dn_o,
    output logic [PUMP_CODE_W-1:0] pump_cur_o,
    output logic                   pump_off_o,
    output logic                   amp_en_o
);

    logic [NUM_CMP_IN-1:0] cmp_lvl;
    logic [NUM_CMP_IN-1:0] cmp_rise;
    pump_cfg_t             cfg_wr;
    pump_cfg_t             cfg_now;
    logic                  pump_busy;

    // Gather the compared inputs into one vector.
    always_comb begin
        cmp_lvl           = '0;
        cmp_lvl[IDX_REF]  = ref_div_i;
        cmp_lvl[IDX_MAIN] = main_div_i;
    end

    // Pack the written settings.
    assign cfg_wr = '{code: cfg_cur_i, off: cfg_off_i};

    pfd_edge_detect #(
        .NUM_CH (NUM_CMP_IN)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (cmp_lvl),
        .rise_o (cmp_rise)
    );

    pfd_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_rise_i  (cmp_rise[IDX_REF]),
        .main_rise_i (cmp_rise[IDX_MAIN]),
        .off_i       (cfg_now.off),
        .up_o        (pump_up_o),
        .dn_o        (pump_dn_o)
    );

    // The pump is busy if a pulse is active or will start at the next clock.
    assign pump_busy = pump_up_o | pump_dn_o | ((|cmp_rise) & ~cfg_now.off);

    pfd_cfg_guard #(
        .AMP_RST (AMP_RST)
    ) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_done_i (cfg_wr_done_i),
        .wr_cfg_i  (cfg_wr),
        .wr_amp_i  (cfg_amp_en_i),
        .busy_i    (pump_busy),
        .cfg_o     (cfg_now),
        .amp_o     (amp_en_o)
    );

    // Drive the applied settings out.
    assign pump_cur_o = cfg_now.code;
    assign pump_off_o = cfg_now.off;

endmodule

// File: rtl/pfd_guarded_pump_chk.sv
// Module: pfd_guarded_pump_chk
// Property checker for pfd_guarded_pump, attached with the bind below.
module pfd_guarded_pump_chk
    import pfd_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ref_rise,
    input logic                   main_rise,
    input logic                   wr_done,
    input logic                   wr_amp,
    input logic                   up,
    input logic                   dn,
    input logic [PUMP_CODE_W-1:0] cur,
    input logic                   off,
    input logic                   amp
);

    // R1: a lone reference rise from idle starts an up pulse.
    p_up_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && !main_rise && !up && !dn && !off) |=> (up && !dn));

    // R2: a lone main rise from idle starts a down pulse.
    p_dn_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (main_rise && !ref_rise && !up && !dn && !off) |=> (dn && !up));

    // R3: an overlap lasts a single cycle.
    p_overlap_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> (!up && !dn));

    // R5: settings hold steady through any pulse cycle.
    p_hold_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (up || dn) |-> ($stable(cur) && $stable(off)));

    // R7: no pulse while the pump is off.
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        off |-> (!up && !dn));

    // R8: the amplifier enable follows the strobed value.
    p_amp_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> (amp == $past(wr_amp)));

endmodule

bind pfd_guarded_pump pfd_guarded_pump_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_rise  (cmp_rise[pfd_pkg::IDX_REF]),
    .main_rise (cmp_rise[pfd_pkg::IDX_MAIN]),
    .wr_done   (cfg_wr_done_i),
    .wr_amp    (cfg_amp_en_i),
    .up        (pump_up_o),
    .dn        (pump_dn_o),
    .cur       (pump_cur_o),
    .off       (pump_off_o),
    .amp       (amp_en_o)
);

// File: tb/pfd_guarded_pump_tb_top.sv
// Scoreboard bench: the driver task pushes the expected outputs for each
// driven cycle, and the monitor pops and compares them after every edge.
module pfd_guarded_pump_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_div = 1'b0;
    logic       main_div = 1'b0;
    logic       wr_done = 1'b0;
    logic [1:0] wr_cur = 2'b00;
    logic       wr_off = 1'b0;
    logic       wr_amp = 1'b1;
    logic       up, dn, off, amp;
    logic [1:0] cur;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic       up;
        logic       dn;
        logic [1:0] cur;
        logic       off;
        logic       amp;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    pfd_guarded_pump dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_div_i     (ref_div),
        .main_div_i    (main_div),
        .cfg_wr_done_i (wr_done),
        .cfg_cur_i     (wr_cur),
        .cfg_off_i     (wr_off),
        .cfg_amp_en_i  (wr_amp),
        .pump_up_o     (up),
        .pump_dn_o     (dn),
        .pump_cur_o    (cur),
        .pump_off_o    (off),
        .amp_en_o      (amp)
    );

    // Driver: set one cycle of inputs and queue the outputs expected after the edge.
    task automatic cyc(input logic rs, input logic r, input logic d,
                       input logic w, input logic [1:0] wc, input logic wo, input logic wa,
                       input logic eu, input logic ed, input logic [1:0] ec,
                       input logic eo, input logic ea, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n    = rs;
        ref_div  = r;
        main_div = d;
        wr_done  = w;
        wr_cur   = wc;
        wr_off   = wo;
        wr_amp   = wa;
        e.up = eu; e.dn = ed; e.cur = ec; e.off = eo; e.amp = ea; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare the outputs shortly after each rising edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() != 0) begin
                e = exp_q.pop_front();
                checks++;
                if ({up, dn, cur, off, amp} !== {e.up, e.dn, e.cur, e.off, e.amp}) begin
                    fails++;
                    $display("FAIL %s: actual up=%b dn=%b cur=%b off=%b amp=%b expected up=%b dn=%b cur=%b off=%b amp=%b",
                             e.tag, up, dn, cur, off, amp, e.up, e.dn, e.cur, e.off, e.amp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Stimulus: args are rst, ref, main, wr, code, off, amp | up, dn, code, off, amp.
    initial begin
        // R9: reset state and nothing waiting afterwards.
        cyc(0, 0,0, 0,2'b00,0,1, 0,0,2'b00,0,1, "R9 reset");
        cyc(0, 0,0, 0,2'b00,0,1, 0,0,2'b00,0,1, "R9 reset");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b00,0,1, "R9 idle after reset");

        // R1: reference leads, then main rise gives the overlap (R3).
        cyc(1, 1,0, 0,2'b00,0,1, 1,0,2'b00,0,1, "R1 up starts");
        cyc(1, 1,0, 0,2'b00,0,1, 1,0,2'b00,0,1, "R1 up held");
        cyc(1, 1,1, 0,2'b00,0,1, 1,1,2'b00,0,1, "R3 overlap");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b00,0,1, "R3 overlap cleared");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b00,0,1, "R1 idle");

        // R2: main leads.
        cyc(1, 0,1, 0,2'b00,0,1, 0,1,2'b00,0,1, "R2 down starts");
        cyc(1, 0,1, 0,2'b00,0,1, 0,1,2'b00,0,1, "R2 down held");
        cyc(1, 1,1, 0,2'b00,0,1, 1,1,2'b00,0,1, "R3 overlap");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b00,0,1, "R3 overlap cleared");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b00,0,1, "R2 idle");

        // R3: coincident edges.
        cyc(1, 1,1, 0,2'b00,0,1, 1,1,2'b00,0,1, "R3 coincident");
        cyc(1, 1,1, 0,2'b00,0,1, 0,0,2'b00,0,1, "R3 coincident cleared");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b00,0,1, "R3 idle");

        // R4: data without strobe ignored; strobed data applied two clocks later.
        cyc(1, 0,0, 0,2'b11,1,0, 0,0,2'b00,0,1, "R4 no strobe");
        cyc(1, 0,0, 0,2'b11,1,0, 0,0,2'b00,0,1, "R4 no strobe");
        cyc(1, 0,0, 1,2'b11,0,1, 0,0,2'b00,0,1, "R4 strobe captured");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b11,0,1, "R4 applied");

        // R5: write during an up pulse waits for the pulse to end.
        cyc(1, 1,0, 0,2'b00,0,1, 1,0,2'b11,0,1, "R5 pulse");
        cyc(1, 1,0, 1,2'b01,0,1, 1,0,2'b11,0,1, "R5 write in pulse");
        cyc(1, 1,0, 0,2'b00,0,1, 1,0,2'b11,0,1, "R5 held");
        cyc(1, 1,1, 0,2'b00,0,1, 1,1,2'b11,0,1, "R5 held in overlap");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b11,0,1, "R5 held at clear");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b01,0,1, "R5 applied when quiet");

        // R6: a newer write replaces a waiting one.
        cyc(1, 1,0, 0,2'b00,0,1, 1,0,2'b01,0,1, "R6 pulse");
        cyc(1, 1,0, 1,2'b10,0,1, 1,0,2'b01,0,1, "R6 first write");
        cyc(1, 1,0, 1,2'b00,0,1, 1,0,2'b01,0,1, "R6 second write");
        cyc(1, 1,1, 0,2'b00,0,1, 1,1,2'b01,0,1, "R6 overlap");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b01,0,1, "R6 clear");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b00,0,1, "R6 newest applied");

        // R5: setting due in the same cycle an edge arrives stays back.
        cyc(1, 0,0, 1,2'b10,0,1, 0,0,2'b00,0,1, "R5 write idle");
        cyc(1, 1,0, 0,2'b00,0,1, 1,0,2'b00,0,1, "R5 edge blocks apply");
        cyc(1, 1,1, 0,2'b00,0,1, 1,1,2'b00,0,1, "R5 overlap");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b00,0,1, "R5 clear");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b10,0,1, "R5 applied after pulse");

        // R7: pump off forces quiet outputs; resumes after re-enable.
        cyc(1, 0,0, 1,2'b10,1,1, 0,0,2'b10,0,1, "R7 off written");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b10,1,1, "R7 off applied");
        cyc(1, 1,0, 0,2'b00,0,1, 0,0,2'b10,1,1, "R7 ref ignored");
        cyc(1, 1,1, 0,2'b00,0,1, 0,0,2'b10,1,1, "R7 main ignored");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b10,1,1, "R7 quiet");
        cyc(1, 0,0, 1,2'b10,0,1, 0,0,2'b10,1,1, "R7 on written");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b10,0,1, "R7 on applied");
        cyc(1, 1,0, 0,2'b00,0,1, 1,0,2'b10,0,1, "R7 detection resumes");
        cyc(1, 1,1, 0,2'b00,0,1, 1,1,2'b10,0,1, "R7 overlap");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b10,0,1, "R7 clear");

        // R8: amplifier enable registered on the strobe, even mid-pulse.
        cyc(1, 0,0, 1,2'b10,0,0, 0,0,2'b10,0,0, "R8 amp off");
        cyc(1, 1,0, 0,2'b00,0,1, 1,0,2'b10,0,0, "R8 amp held");
        cyc(1, 1,0, 1,2'b10,0,1, 1,0,2'b10,0,1, "R8 amp on mid-pulse");
        cyc(1, 1,1, 0,2'b00,0,1, 1,1,2'b10,0,1, "R8 overlap");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b10,0,1, "R8 clear");
        cyc(1, 0,0, 0,2'b00,0,1, 0,0,2'b10,0,1, "R8 idle");

        wait (exp_q.size() == 0);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule